// File: doc/BRIEF.md
# Snapshot Interrupt Priority Vector Port

This block is a read-only location on an 8-bit processor bus. It gathers eight active-low interrupt request lines and returns a byte that a handler adds to the base of an indexed indirect jump table. The highest-numbered pending request wins. Its index is doubled so that each source owns one 2-byte table entry. When nothing is pending, the port returns a separate ninth code that points at a final table entry for spurious interrupts or for a clean exit.

The request lines are asynchronous to the bus clock, so each one passes through a synchroniser. A holding register follows the synchronised requests while the port is idle. It stops changing for as long as a read of the port is in progress. Every bit placed on the data bus therefore comes from one consistent sample. A request that arrives partway through a read waits for the next read. The block also drives a combined active-low interrupt line to the processor. This line follows the synchronised requests and ignores the read snapshot. The data byte carries a separate drive-enable output for the external bus pads, and that enable is high only while the port is being read.

Top module: `irq_vector_port`

## Requirements
- R1: Each request input `irq_n_i[k]` is active low. A 0 on bit k means source k is requesting service.
- R2: When one or more requests are active, the read byte is 2×k, where k is the highest-numbered active request.
- R3: With no active request, the read byte is 16 (0x10, only bit 4 set).
- R4: In every read byte, bit 0 and bits 7 to 5 are zero.
- R5: The sample is frozen while `sel_i` and `rd_i` are both high. Request changes during that time, including ones of higher priority, do not alter the byte being driven.
- R6: While the port is not being read, the holding register follows the synchronised requests, so the next read reflects changes made while idle.
- R7: `data_oe_o` rises on the first rising edge at which `sel_i && rd_i` is sampled high and falls on the first edge at which it is sampled low. While `data_oe_o` is low, `data_o` is zero. `rd_i` has no effect while `sel_i` is low.
- R8: `irq_n_o` is low whenever any synchronised request is active, including during a frozen read. It follows a change on `irq_n_i` after 3 rising edges.
- R9: A write (`sel_i && wr_i` with `rd_i` low) does not drive the bus and changes no state.
- R10: A request level that is stable for at least 3 rising edges before the edge at which a read is first sampled appears in that read's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_i | input | 8 | Active-low interrupt requests, asynchronous |
| sel_i | input | 1 | Port address decode select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe (ignored) |
| data_o | output | 8 | Vector offset byte, zero when not driving |
| data_oe_o | output | 1 | Data bus pad drive enable |
| irq_n_o | output | 1 | Combined active-low interrupt to the processor |

## Verification
The central corner case is a request that arrives during a read, first one of higher priority and then the release of every request. A design whose holding register stays transparent during the read would change the driven byte mid-access, and this would show up as the byte moving from 2 to 14 or to 16. The bench also checks that the combined interrupt line still follows those changes during the frozen read, that a read taken after idle time picks up what changed, and that the empty case returns 16 rather than 0 or 14. Reads with `sel_i` low and write cycles are tried, because a loose decode would drive the bus or freeze the sample on those cycles.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_op_e;

  localparam int SYNC_MIN_STAGES = 2;

endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '1;
        else     stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '1;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqv_snap.sv
module irqv_snap #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze_i,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] held_o
);

  always_ff @(posedge clk) begin
    if (rst)            held_o <= '0;
    else if (!freeze_i) held_o <= req_i;
  end

  // R5: the held sample must not move across a cycle in which a read was active
  assert_snapshot_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(freeze_i)) |-> $stable(held_o));

  // R6: when not frozen, the held sample picks up the request vector
  assert_snapshot_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(freeze_i)) |-> (held_o == $past(req_i)));

endmodule

// File: rtl/irqv_encode.sv
module irqv_encode #(
  parameter int N_REQ  = 8,
  parameter int DATA_W = 8
) (
  input  logic [N_REQ-1:0]  req_i,
  output logic [DATA_W-1:0] code_o
);

  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam logic [DATA_W-1:0] NONE_CODE = DATA_W'(2 * N_REQ);

  logic             found;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_i[i]) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
    code_o = found ? (DATA_W'(win_idx) << 1) : NONE_CODE;
  end

endmodule

// File: rtl/irq_vector_port.sv
module irq_vector_port #(
  parameter int N_REQ       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_REQ-1:0]  irq_n_i,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              irq_n_o
);
  import irqv_pkg::*;

  localparam int TOP_BIT = $clog2(2 * N_REQ);

  bus_op_e          bus_op;
  logic             read_act;
  logic [N_REQ-1:0] sync_n;
  logic [N_REQ-1:0] req_live;
  logic [N_REQ-1:0] req_held;
  logic [DATA_W-1:0] code;

  always_comb begin
    if (sel_i && rd_i)      bus_op = BUS_READ;
    else if (sel_i && wr_i) bus_op = BUS_WRITE;
    else                    bus_op = BUS_IDLE;
  end

  assign read_act = (bus_op == BUS_READ);

  irqv_sync #(.WIDTH(N_REQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (irq_n_i),
    .sync_o  (sync_n)
  );

  assign req_live = ~sync_n;

  irqv_snap #(.WIDTH(N_REQ)) u_snap (
    .clk      (clk),
    .rst      (rst),
    .freeze_i (read_act),
    .req_i    (req_live),
    .held_o   (req_held)
  );

  irqv_encode #(.N_REQ(N_REQ), .DATA_W(DATA_W)) u_enc (
    .req_i  (req_held),
    .code_o (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
      irq_n_o   <= 1'b1;
    end else begin
      data_o    <= read_act ? code : '0;
      data_oe_o <= read_act;
      irq_n_o   <= ~(|req_live);
    end
  end

  // R7: pads are driven only in the cycle after a selected read was sampled
  assert_drive_only_on_read_R7: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> $past(sel_i && rd_i));

  // R7: undriven bus carries zero
  assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (rst)
    !data_oe_o |-> (data_o == '0));

  // R4: byte is even and has no bits above the none-code bit
  assert_code_shape_R4: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> (!data_o[0] && ((data_o >> (TOP_BIT + 1)) == '0)));

  // R3: the none-code bit is never combined with an index
  assert_none_code_alone_R3: assert property (@(posedge clk) disable iff (rst)
    data_o[TOP_BIT] |-> (data_o == DATA_W'(2 * N_REQ)));

  // R9: a write cycle never enables the pads
  assert_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (sel_i && wr_i && !rd_i) |=> !data_oe_o);

endmodule

// File: tb/irq_vector_port_test.sv
module irq_vector_port_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] irq_n;
  logic       sel, rd, wr;
  logic [7:0] data;
  logic       oe;
  logic       irq_out_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  irq_vector_port uut (
    .clk       (clk),
    .rst       (rst),
    .irq_n_i   (irq_n),
    .sel_i     (sel),
    .rd_i      (rd),
    .wr_i      (wr),
    .data_o    (data),
    .data_oe_o (oe),
    .irq_n_o   (irq_out_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic begin_read();
    @(negedge clk);
    sel = 1'b1; rd = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_read();
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_expect(input string tag, input int exp);
    begin_read();
    check({tag, " oe"}, int'(oe), 1);
    check(tag, int'(data), exp);
    check("R4 shape", int'(data & 8'hE1), 0);
    end_read();
    check("R7 release", int'(oe), 0);
    check("R7 zero", int'(data), 0);
  endtask

  task automatic t_reset();
    check("R7 reset oe", int'(oe), 0);
    check("R7 reset data", int'(data), 0);
    check("R8 reset irq", int'(irq_out_n), 1);
    read_expect("R3 none after reset", 16);
  endtask

  task automatic t_single();
    for (int i = 0; i < 8; i++) begin
      set_irq(~(8'd1 << i));
      check("R8 irq low", int'(irq_out_n), 0);
      read_expect("R1 R2 single", 2 * i);
    end
  endtask

  task automatic t_multi();
    set_irq(8'h00);
    read_expect("R2 all active", 14);
    set_irq(8'b1011_0111);
    read_expect("R2 bits 3 and 6", 12);
    set_irq(8'b1111_1010);
    read_expect("R2 bits 0 and 2", 4);
    set_irq(8'hFF);
    check("R8 irq high", int'(irq_out_n), 1);
    read_expect("R3 none", 16);
  endtask

  task automatic t_snapshot();
    set_irq(8'b1111_1101);
    begin_read();
    check("R5 first", int'(data), 2);
    irq_n = 8'b0111_1101;
    repeat (5) @(negedge clk);
    check("R5 higher late", int'(data), 2);
    check("R8 live in read", int'(irq_out_n), 0);
    irq_n = 8'hFF;
    repeat (5) @(negedge clk);
    check("R5 release late", int'(data), 2);
    check("R5 oe held", int'(oe), 1);
    check("R8 high in read", int'(irq_out_n), 1);
    end_read();
    check("R7 end", int'(oe), 0);
    repeat (2) @(negedge clk);
    read_expect("R6 idle track none", 16);
    set_irq(8'b0111_1111);
    read_expect("R6 R10 idle track 7", 14);
  endtask

  task automatic t_unselected();
    set_irq(8'b1110_1111);
    @(negedge clk);
    sel = 1'b0; rd = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 no sel oe", int'(oe), 0);
    check("R7 no sel data", int'(data), 0);
    irq_n = 8'b1111_1011;
    repeat (3) @(negedge clk);
    rd = 1'b0;
    read_expect("R7 R6 rd without sel no freeze", 4);
  endtask

  task automatic t_write();
    set_irq(8'b1101_1111);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1;
    @(negedge clk);
    check("R9 write oe", int'(oe), 0);
    check("R9 write data", int'(data), 0);
    irq_n = 8'b1111_0111;
    repeat (4) @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    read_expect("R9 state after write", 6);
    check("R8 after write", int'(irq_out_n), 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_n = 8'hFF; sel = 1'b0; rd = 1'b0; wr = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_snapshot();
    t_unselected();
    t_write();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule